// File: doc/BRIEF.md
# Clock Synthesizer Configuration Store and Row Selector

This block keeps the configuration word of a clock synthesizer and decides which stored copy drives the synthesizer. It holds two write-once configuration rows and a freely rewritable shadow register of the same layout. A single write port loads any of the three. Each row carries a valid bit that locks the row against further writes. The block drives the selected word out through a register, together with a code that says where the word came from.

A two-bit variant input picks the selection rules. In the standard variant the shadow register is live until a row has been committed, and row 1 then serves as a one-time reprogramming slot that takes over from row 0. In the frequency-select variant a select pin chooses between row 0 and row 1, and row 1 holds an alternate frequency rather than a replacement. A separate variant bit disables the shadow register, so the output always comes from a row.

Top module: `cfgsel_top`

## Requirements
- R1: The 36-bit configuration word is packed from bit 35 down as: feedback count (12 bits, 35:24), reference count (10 bits, 23:14), post-divide select (3 bits, 13:11), source select (bit 10, 1 = PLL), oscillator tuning (7 bits, 9:3), output level (bit 2, 1 = CMOS), power-management mode (bit 1) and power-management timing (bit 0).
- R2: Reset clears the shadow register, both valid bits, `activeCfg` and `wrErr`, and sets `activeSrc` to 0. Data already stored in a row survives reset.
- R3: A write with `wrTarget` = 0 loads the shadow register any number of times. When the shadow register is the live source, its new value appears on `activeCfg` after the second rising edge following the write.
- R4: A write with `wrTarget` = 1 (row 0) or 2 (row 1) to an unlocked row stores the data and sets that row's valid bit, which locks the row until reset.
- R5: A write to a locked row leaves its data unchanged and drives `wrErr` high for exactly the one cycle after the write.
- R6: With `variantMode[0]` = 0 (standard), a valid row 1 is used, otherwise a valid row 0, otherwise the shadow register.
- R7: With `variantMode[0]` = 1 (frequency select), `fsPin` = 0 selects row 0 and `fsPin` = 1 selects row 1. If the selected row is not valid and the shadow register is enabled, the shadow register is used.
- R8: With `variantMode[1]` = 1 (shadow disabled), `activeSrc` never reports the shadow register. In the standard variant with no valid row, row 0 is used. In the frequency-select variant the pin-selected row is used even if it is not valid.
- R9: `activeCfg` and `activeSrc` are registered. They change on the first rising edge after a change in selection inputs or in valid bits.
- R10: A write with the reserved `wrTarget` code 3 changes no stored word and does not raise `wrErr`.
- R11: `activeSrc` encodes the source as 0 = shadow, 1 = row 0 and 2 = row 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| wrTarget | input | 2 | Write destination: 0 shadow, 1 row 0, 2 row 1, 3 reserved |
| wrData | input | 36 | Configuration word to write |
| fsPin | input | 1 | Row select used in the frequency-select variant |
| variantMode | input | 2 | Bit 0: frequency-select variant; bit 1: shadow disabled |
| activeCfg | output | 36 | Registered live configuration word |
| activeSrc | output | 2 | Registered source of the live word |
| wrErr | output | 1 | One-cycle flag for a write to a locked row |

## Verification
The bench builds the block with its default field widths, which give a 36-bit word and two rows. All four variant codes are therefore reachable at run time from one build. One pass of vectors takes the rows from blank to locked in the standard variant and then switches variants with both rows valid. A second pass after reset covers the state where rows hold data but no valid bits are set. That state only exists because reset preserves row contents, and it shows the shadow-disabled rules and the re-opened write lock.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
  localparam int FB_W     = 12;
  localparam int REF_W    = 10;
  localparam int DIV_W    = 3;
  localparam int TUNE_W   = 7;
  localparam int NUM_ROWS = 2;

  // packed MSB first; field order is the word layout seen by the synthesizer
  typedef struct packed {
    logic [FB_W-1:0]   fbCount;
    logic [REF_W-1:0]  refCount;
    logic [DIV_W-1:0]  postDiv;
    logic              srcPll;
    logic [TUNE_W-1:0] tune;
    logic              levelCmos;
    logic              pmMode;
    logic              pmSync;
  } cfgWord_t;

  localparam int CFG_W = $bits(cfgWord_t);

  typedef enum logic [1:0] {
    TGT_SHADOW = 2'd0,
    TGT_ROW0   = 2'd1,
    TGT_ROW1   = 2'd2,
    TGT_RSVD   = 2'd3
  } wrTarget_e;

  typedef enum logic [1:0] {
    SRC_SHADOW = 2'd0,
    SRC_ROW0   = 2'd1,
    SRC_ROW1   = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic                wrShadow;
    logic [NUM_ROWS-1:0] wrRow;
    srcSel_e             srcSel;
  } ctrlStb_t;
endpackage

// File: rtl/cfgsel_ctrl.sv
module cfgsel_ctrl import cfgsel_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrTarget,
  input  logic       fsPin,
  input  logic [1:0] variantMode,
  output ctrlStb_t   stb,
  output logic       wrErr
);
  logic [NUM_ROWS-1:0] rowValid;
  logic [NUM_ROWS-1:0] rowHit;
  logic [NUM_ROWS-1:0] rowWr;
  logic                fsVariant;
  logic                shadowOff;
  srcSel_e             pinRow;
  srcSel_e             selNext;

  assign fsVariant = variantMode[0];
  assign shadowOff = variantMode[1];

  generate
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      assign rowHit[i] = wrEn && (wrTarget == 2'(i + 1));
      assign rowWr[i]  = rowHit[i] && !rowValid[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          rowValid[i] <= 1'b0;
        else if (rowHit[i]) rowValid[i] <= 1'b1;
      end

      // R4: a committed row stays locked until reset
      a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
        rowValid[i] |=> rowValid[i]);
      // R5: hitting a locked row flags an error on the next cycle
      a_r5_locked_flag: assert property (@(posedge clk) disable iff (!rstN)
        rowHit[i] && rowValid[i] |=> wrErr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= |(rowHit & rowValid);
  end

  // R5: the error flag only ever follows a write request
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn));

  always_comb begin
    pinRow = fsPin ? SRC_ROW1 : SRC_ROW0;
    if (fsVariant) begin
      selNext = (rowValid[fsPin] || shadowOff) ? pinRow : SRC_SHADOW;
    end else if (rowValid[1]) begin
      selNext = SRC_ROW1;
    end else if (rowValid[0] || shadowOff) begin
      selNext = SRC_ROW0;
    end else begin
      selNext = SRC_SHADOW;
    end
  end

  always_comb begin
    stb.wrShadow = wrEn && (wrTarget == TGT_SHADOW);
    stb.wrRow    = rowWr;
    stb.srcSel   = selNext;
  end
endmodule

// File: rtl/cfgsel_store.sv
module cfgsel_store import cfgsel_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  input  cfgWord_t wrData,
  output cfgWord_t activeCfg,
  output srcSel_e  activeSrc
);
  cfgWord_t shadowQ;
  cfgWord_t rowQ [NUM_ROWS];
  cfgWord_t nextCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shadowQ <= '0;
    else if (stb.wrShadow) shadowQ <= wrData;
  end

  // rows keep their contents through reset, so they carry no reset term
  generate
    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
      always_ff @(posedge clk) begin
        if (stb.wrRow[i]) rowQ[i] <= wrData;
      end
    end
  endgenerate

  always_comb begin
    case (stb.srcSel)
      SRC_ROW0: nextCfg = rowQ[0];
      SRC_ROW1: nextCfg = rowQ[1];
      default:  nextCfg = shadowQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCfg <= '0;
      activeSrc <= SRC_SHADOW;
    end else begin
      activeCfg <= nextCfg;
      activeSrc <= stb.srcSel;
    end
  end

  // R3: while the shadow is live the output carries its previous-cycle value
  a_r3_shadow_path: assert property (@(posedge clk) disable iff (!rstN)
    activeSrc == SRC_SHADOW |-> activeCfg == $past(shadowQ));
endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top import cfgsel_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrTarget,
  input  logic [CFG_W-1:0] wrData,
  input  logic             fsPin,
  input  logic [1:0]       variantMode,
  output logic [CFG_W-1:0] activeCfg,
  output logic [1:0]       activeSrc,
  output logic             wrErr
);
  ctrlStb_t stb;
  cfgWord_t cfgQ;
  srcSel_e  srcQ;

  cfgsel_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrTarget    (wrTarget),
    .fsPin       (fsPin),
    .variantMode (variantMode),
    .stb         (stb),
    .wrErr       (wrErr)
  );

  cfgsel_store u_store (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (cfgWord_t'(wrData)),
    .activeCfg (cfgQ),
    .activeSrc (srcQ)
  );

  assign activeCfg = cfgQ;
  assign activeSrc = srcQ;

  // R8: with the shadow disabled for a full cycle it is never reported live
  a_r8_no_shadow: assert property (@(posedge clk) disable iff (!rstN)
    variantMode[1] && $past(variantMode[1]) && $past(rstN) |-> activeSrc != 2'd0);
  // R11: the reserved source code never appears
  a_r11_src_code: assert property (@(posedge clk) disable iff (!rstN)
    activeSrc != 2'd3);
endmodule

// File: tb/sim_cfgsel_top.sv
`timescale 1ns/100ps
module sim_cfgsel_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrTarget = 2'd0;
  logic [35:0] wrData = '0;
  logic        fsPin = 1'b0;
  logic [1:0]  variantMode = 2'd0;
  logic [35:0] activeCfg;
  logic [1:0]  activeSrc;
  logic        wrErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgsel_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrTarget(wrTarget), .wrData(wrData),
    .fsPin(fsPin), .variantMode(variantMode), .activeCfg(activeCfg),
    .activeSrc(activeSrc), .wrErr(wrErr)
  );

  localparam logic [35:0] DA = 36'h123456789;
  localparam logic [35:0] DB = 36'h9ABCDEF01;
  localparam logic [35:0] DC = 36'h5A5A5A5A5;
  localparam logic [35:0] DD = 36'hF0F0F0F0F;

  typedef struct packed {
    logic        wr;
    logic [1:0]  tgt;
    logic [35:0] data;
    logic        fs;
    logic [1:0]  vm;
    logic [1:0]  src;
    logic [35:0] cfg;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, DA, 1'b0, 2'd0, 2'd0, DA, 1'b0},  // R3 shadow write
    '{1'b1, 2'd0, DB, 1'b0, 2'd0, 2'd0, DB, 1'b0},  // R3 rewrite
    '{1'b1, 2'd1, DC, 1'b0, 2'd0, 2'd1, DC, 1'b0},  // R4 R6 commit row 0
    '{1'b1, 2'd0, DA, 1'b0, 2'd0, 2'd1, DC, 1'b0},  // R6 shadow hidden
    '{1'b1, 2'd1, DD, 1'b0, 2'd0, 2'd1, DC, 1'b1},  // R5 locked row 0
    '{1'b1, 2'd2, DD, 1'b0, 2'd0, 2'd2, DD, 1'b0},  // R6 row 1 priority
    '{1'b1, 2'd2, DA, 1'b0, 2'd0, 2'd2, DD, 1'b1},  // R5 locked row 1
    '{1'b1, 2'd3, DB, 1'b0, 2'd0, 2'd2, DD, 1'b0},  // R10 reserved code
    '{1'b0, 2'd0, DA, 1'b0, 2'd1, 2'd1, DC, 1'b0},  // R7 pin low
    '{1'b0, 2'd0, DA, 1'b1, 2'd1, 2'd2, DD, 1'b0},  // R7 pin high
    '{1'b0, 2'd0, DA, 1'b1, 2'd3, 2'd2, DD, 1'b0},  // R8 no shadow, pin high
    '{1'b0, 2'd0, DA, 1'b0, 2'd3, 2'd1, DC, 1'b0}   // R8 no shadow, pin low
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one write, check error flag after one edge, word after two
  task automatic doWrite(input logic [1:0] tgt, input logic [35:0] d, input string req,
                         input logic expErr, input logic [1:0] expSrc, input logic [35:0] expCfg);
    wrEn = 1'b1; wrTarget = tgt; wrData = d;
    @(posedge clk); @(negedge clk);
    chk({req, " err"}, 64'(wrErr), 64'(expErr));
    wrEn = 1'b0;
    @(posedge clk); @(negedge clk);
    chk({req, " src"}, 64'(activeSrc), 64'(expSrc));
    chk({req, " cfg"}, 64'(activeCfg), 64'(expCfg));
  endtask

  task automatic settle(input string req, input logic [1:0] expSrc, input logic [35:0] expCfg);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({req, " src"}, 64'(activeSrc), 64'(expSrc));
    chk({req, " cfg"}, 64'(activeCfg), 64'(expCfg));
  endtask

  function automatic void finish();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endfunction

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

  initial begin
    logic [35:0] fw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    chk("R2 reset cfg", 64'(activeCfg), 64'd0);
    chk("R2 reset src", 64'(activeSrc), 64'd0);
    chk("R2 reset err", 64'(wrErr), 64'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      fsPin = VECS[k].fs; variantMode = VECS[k].vm;
      wrEn = VECS[k].wr; wrTarget = VECS[k].tgt; wrData = VECS[k].data;
      @(posedge clk); @(negedge clk);
      chk($sformatf("vec%0d err", k), 64'(wrErr), 64'(VECS[k].err));
      wrEn = 1'b0;
      @(posedge clk); @(negedge clk);
      chk($sformatf("vec%0d src", k), 64'(activeSrc), 64'(VECS[k].src));
      chk($sformatf("vec%0d cfg", k), 64'(activeCfg), 64'(VECS[k].cfg));
    end

    // R2 second reset: valid bits and shadow cleared, rows kept
    rstN = 1'b0; variantMode = 2'd0; fsPin = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 rereset cfg", 64'(activeCfg), 64'd0);
    chk("R2 rereset src", 64'(activeSrc), 64'd0);
    rstN = 1'b1;
    settle("R2 shadow cleared", 2'd0, 36'd0);

    // R1 field placement through the shadow
    fw = {12'hABC, 10'h155, 3'd5, 1'b1, 7'h2A, 1'b0, 1'b1, 1'b0};
    doWrite(2'd0, fw, "R1 R3 layout", 1'b0, 2'd0, fw);
    chk("R1 feedback", 64'(activeCfg[35:24]), 64'h0ABC);
    chk("R1 reference", 64'(activeCfg[23:14]), 64'h155);
    chk("R1 postdiv", 64'(activeCfg[13:11]), 64'd5);
    chk("R1 tune", 64'(activeCfg[9:3]), 64'h2A);
    chk("R1 pm bits", 64'(activeCfg[2:0]), 64'b010);

    // R2 R8 rows preserved, visible with shadow disabled
    @(negedge clk); variantMode = 2'd2;
    settle("R2 R8 preserved row0", 2'd1, DC);
    // R7 pin selects invalid row, shadow enabled -> shadow
    @(negedge clk); variantMode = 2'd1; fsPin = 1'b1;
    settle("R7 invalid row falls back", 2'd0, fw);
    // R4 lock reopened by reset
    @(negedge clk); variantMode = 2'd2; fsPin = 1'b0;
    doWrite(2'd1, DD, "R4 rewrite row0", 1'b0, 2'd1, DD);
    @(negedge clk); variantMode = 2'd1;
    doWrite(2'd2, DA, "R4 row1 alt", 1'b0, 2'd1, DD);

    // R9 exact timing of a selection change
    @(negedge clk); fsPin = 1'b1;
    #1;
    chk("R9 before edge src", 64'(activeSrc), 64'd1);
    @(posedge clk); #1;
    chk("R9 after edge src", 64'(activeSrc), 64'd2);
    chk("R9 after edge cfg", 64'(activeCfg), 64'(DA));

    finish();
  end
endmodule